// File: doc/BRIEF.md
# Shift-Add Three-Tap Transposed FIR Filter

This block is a three-tap finite impulse response filter with the fixed coefficients 3, 53 and 583. It is built in transposed direct form. Each accepted input sample is scaled by all three coefficients in the same cycle. The scaling is done by one constant-multiplication unit that has no multiplier. It uses shifts and five adders, and intermediate sums are reused across the three products: the x3 term feeds the x53 term, and the x53 term feeds the x583 term.

The three products enter a short chain of registers. The x583 product is held in a far tap. The x53 product is added to the far tap and held in a near tap. The x3 product is added to the near tap and registered as the output. The chain advances only on cycles when the input strobe is high. Gaps between samples therefore do not count as samples.

The output is full precision: the input width plus 10 bits. The coefficients sum to 639, which is below 2^10, so the output can never overflow. A data source drives samples with a strobe, and a data sink accepts the result on the output strobe.

The block has no state machine. The only sequencing is the tap chain advancing on accepted samples.

Top module: `fir3_shiftadd`

## Requirements
- R1: A synchronous active-high reset clears the output, the output strobe and both tap registers. After reset, the first results depend only on samples accepted after the reset.
- R2: For accepted samples x[n], the output equals 3·x[n] + 53·x[n-1] + 583·x[n-2]. It appears on the clock edge that follows the edge at which x[n] was accepted.
- R3: An input of 1 followed by zeros produces the output sequence 3, 53, 583, 0.
- R4: The output strobe is high in exactly the cycle after each cycle in which the input strobe was high, and low otherwise.
- R5: While the input strobe is low, the input data is ignored. The output value and both taps hold, and the idle cycles are not counted as samples.
- R6: The output is signed and W+10 bits wide. Runs of the most negative and most positive input values give exact results, with no wrap.
- R7: The three products equal 3x, 53x and 583x. They are formed with shifts and five adders that share sub-sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | W | Signed input sample |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_sample | output | W+10 | Signed full-precision filtered output |

## Verification
An impulse, and a lone sample of 5 surrounded by zeros, isolate each coefficient. These patterns separate a wrong shift or a wrongly shared sub-sum in any one product, and they also separate a swapped tap order. Back-to-back random samples exercise the full three-term sum. The same samples with random idle gaps, during which the data input carries noise, separate a chain that advances only on the strobe from one that advances every cycle. Runs of the minimum and maximum values, alternating or held, separate a full-width datapath from one that truncates or wraps. A reset in the middle of a stream shows whether stale tap contents leak into later results.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
    localparam int GAIN_BITS = 10;
    localparam int COEF_H0   = 3;
    localparam int COEF_H1   = 53;
    localparam int COEF_H2   = 583;
endpackage

// File: rtl/fir3_shiftadd_mcm.sv
module fir3_shiftadd_mcm #(
    parameter int W  = 12,
    parameter int OW = W + fir3_pkg::GAIN_BITS
) (
    input  logic signed [W-1:0]  x,
    output logic signed [OW-1:0] p_h0,
    output logic signed [OW-1:0] p_h1,
    output logic signed [OW-1:0] p_h2
);
    localparam int EXT = OW - W;

    logic signed [OW-1:0] xe;
    logic signed [OW-1:0] t3;
    logic signed [OW-1:0] t53;
    logic signed [OW-1:0] t583;

    assign xe = {{EXT{x[W-1]}}, x};

    // adder 1: x*3 = x + 2x
    assign t3   = xe + (xe <<< 1);
    // adders 2,3: x*53 = 16*(3x) + 4x + x  (reuses t3)
    assign t53  = (t3 <<< 4) + (xe <<< 2) + xe;
    // adders 4,5: x*583 = 8*(53x) + 2*(53x) + 53x  (reuses t53)
    assign t583 = (t53 <<< 3) + (t53 <<< 1) + t53;

    assign p_h0 = t3;
    assign p_h1 = t53;
    assign p_h2 = t583;

    always_comb begin
        assert_prod_h0_R7: assert (p_h0 == xe * fir3_pkg::COEF_H0);
        assert_prod_h1_R7: assert (p_h1 == xe * fir3_pkg::COEF_H1);
        assert_prod_h2_R7: assert (p_h2 == xe * fir3_pkg::COEF_H2);
    end
endmodule

// File: rtl/fir3_tdf_chain.sv
module fir3_tdf_chain #(
    parameter int OW = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld,
    input  logic signed [OW-1:0] p_h0,
    input  logic signed [OW-1:0] p_h1,
    input  logic signed [OW-1:0] p_h2,
    output logic                 y_vld,
    output logic signed [OW-1:0] y
);
    logic signed [OW-1:0] tap_near;
    logic signed [OW-1:0] tap_far;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_near <= '0;
            tap_far  <= '0;
            y        <= '0;
            y_vld    <= 1'b0;
        end else begin
            y_vld <= vld;
            if (vld) begin
                y        <= p_h0 + tap_near;
                tap_near <= p_h1 + tap_far;
                tap_far  <= p_h2;
            end
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !vld |=> ($stable(y) && $stable(tap_near) && $stable(tap_far)));
    assert_strobe_on_R4: assert property (@(posedge clk) disable iff (rst)
        vld |=> y_vld);
    assert_strobe_off_R4: assert property (@(posedge clk) disable iff (rst)
        !vld |=> !y_vld);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!y_vld && y == '0 && tap_near == '0 && tap_far == '0));
endmodule

// File: rtl/fir3_shiftadd.sv
module fir3_shiftadd #(
    parameter int W  = 12,
    parameter int OW = W + fir3_pkg::GAIN_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_sample,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_sample
);
    logic signed [OW-1:0] prod_h0;
    logic signed [OW-1:0] prod_h1;
    logic signed [OW-1:0] prod_h2;

    fir3_shiftadd_mcm #(.W(W), .OW(OW)) u_mcm (
        .x    (in_sample),
        .p_h0 (prod_h0),
        .p_h1 (prod_h1),
        .p_h2 (prod_h2)
    );

    fir3_tdf_chain #(.OW(OW)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .vld   (in_valid),
        .p_h0  (prod_h0),
        .p_h1  (prod_h1),
        .p_h2  (prod_h2),
        .y_vld (out_valid),
        .y     (out_sample)
    );
endmodule

// File: tb/fir3_shiftadd_bench.sv
`timescale 1ns/1ps
module fir3_shiftadd_bench;
    localparam int W  = 12;
    localparam int OW = W + 10;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_sample = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_sample;

    fir3_shiftadd #(.W(W), .OW(OW)) u_fir3_shiftadd (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #2.5 clk = ~clk;

    int      checks = 0;
    int      errors = 0;
    longint  exp_q[$];
    string   tag_q[$];
    longint  hx1 = 0;
    longint  hx2 = 0;
    bit      mon_en = 1'b0;
    bit      done = 1'b0;
    logic signed [OW-1:0] last_out = '0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic signed [W-1:0] x, input string tag);
        @(posedge clk); #1;
        in_valid  = 1'b1;
        in_sample = x;
        exp_q.push_back(3 * longint'(x) + 53 * hx1 + 583 * hx2);
        tag_q.push_back(tag);
        hx2 = hx1;
        hx1 = longint'(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid  = 1'b0;
            in_sample = W'($urandom);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        mon_en   = 1'b0;
        rst      = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        hx1 = 0;
        hx2 = 0;
        @(negedge clk);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 out_sample after reset", longint'(out_sample), 0);
        last_out = out_sample;
        mon_en = 1'b1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected out_valid", 1, 0);
                end else begin
                    check(tag_q.pop_front(), longint'(out_sample), exp_q.pop_front());
                end
            end else begin
                check("R5 hold while idle", longint'(out_sample), longint'(last_out));
            end
            last_out = out_sample;
        end
    end

    initial begin
        do_reset();
        // R3 impulse
        send(12'sd1, "R3 impulse");
        for (int i = 0; i < 3; i++) send(12'sd0, "R3 impulse");
        idle(3);
        // R7 lone sample isolates products 15, 265, 2915
        send(12'sd5, "R7 products");
        for (int i = 0; i < 3; i++) send(12'sd0, "R7 products");
        idle(2);
        // R2 back-to-back random
        for (int i = 0; i < 40; i++) send(W'($urandom), "R2 random stream");
        idle(5);
        // R5 gapped stream with noisy idle data
        for (int i = 0; i < 30; i++) begin
            send(W'($urandom), "R5 gapped stream");
            idle(int'($urandom_range(0, 2)));
        end
        idle(2);
        // R6 extremes
        for (int i = 0; i < 4; i++) send(-12'sd2048, "R6 min run");
        for (int i = 0; i < 4; i++) send(12'sd2047, "R6 max run");
        for (int i = 0; i < 6; i++) begin
            send(-12'sd2048, "R6 alternating");
            send(12'sd2047, "R6 alternating");
        end
        idle(3);
        // R1 reset mid-stream clears taps
        for (int i = 0; i < 3; i++) send(12'sd1000, "R1 pre-reset");
        idle(2);
        do_reset();
        send(12'sd7, "R1 fresh after reset");
        send(12'sd0, "R1 fresh after reset");
        idle(4);
        check("R4 all results delivered", longint'(exp_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule